// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. Software fills either of two packet buffers with 32-bit word writes over a simple word-addressed bus. It then writes that buffer's length and control registers. One control encoding streams the buffer's first N bytes as a byte-wide valid/ready/last stream toward a framer. The other encoding copies the buffer's first six bytes into the 48-bit station address.

A single sequencer serves the two buffers one at a time. A buffer's status bit reads back as busy until its operation ends. When the operation ends, a one-cycle interrupt pulse is raised if that buffer's enable bit and the single global enable both allow it. Preamble, CRC, line timing and reception are handled elsewhere.

Top module: `dualbuf_eth_tx`

## Requirements
- R1: After reset every control register reads 0, the global enable reads 0, `irq` and `tx_valid` are low and `station_addr` equals the `RESET_ADDR` parameter.
- R2: Byte offsets are decoded as follows. Buffer 0 data starts at 0x000, its length is at 0x7F4, the global enable is bit 31 of 0x7F8 and its control register is at 0x7FC. Buffer 1 data starts at 0x800, its length is at 0xFF4 and its control register is at 0xFFC. A read returns data on `bus_rdata` in the cycle after `bus_rd`. The length register keeps its low 12 bits. Offsets 0x1000 and above read 0 and ignore writes.
- R3: A control write with bit 0 = 1 and bit 1 = 0 streams the length-register count of bytes from that buffer. Bytes go lowest address first, and the least significant byte of each word goes first. `tx_last` is high on the final byte only.
- R4: Control bit 0 reads 1 from the accepted start until completion and 0 afterwards. The control register reads back bit 3 as the interrupt enable and bit 1 as the last written program bit.
- R5: A control write with bits 0 and 1 both set loads `station_addr` with no stream output. Bits [47:40] take buffer byte 0, and so on down to bits [7:0], which take byte 5.
- R6: `irq` is a single-cycle pulse in the cycle after an operation completes. It is raised only if that buffer's control bit 3 and bit 31 of offset 0x7F8 are both set.
- R7: Offset 0xFF8 reads 0 and writing it has no effect on interrupts.
- R8: A control write to a buffer whose status bit is still set changes nothing in that buffer.
- R9: A start written to one buffer in the same cycle that the other buffer's transfer completes is served next. No byte of either frame is lost, and each frame gives its own interrupt.
- R10: A length of 0 completes with no bytes sent. A length above 2036 is treated as 2036.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 13 | Byte offset (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_last | output | 1 | Final byte of the frame |
| station_addr | output | 48 | Station MAC address |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two events can share a clock edge: the completion of one buffer's transfer and a bus control write that starts the other buffer. The bench keeps `tx_ready` high and watches for the negative edge at which `tx_last` is shown. At that edge it drives the start for the second buffer, so the write and the final handshake land on the same rising edge. The outcome is judged at the ports. The captured stream must hold both frames back to back, in order and byte-exact, with exactly two `tx_last` beats and two interrupt pulses.

// File: rtl/etx_pkg.sv
package etx_pkg;

  // Map geometry: each buffer region spans 512 words; top three words are registers.
  localparam int unsigned ETX_ADDR_W     = 13;
  localparam int unsigned ETX_WIDX_W     = 9;
  localparam int unsigned ETX_DATA_WORDS = 509;
  localparam logic [8:0]  W_LEN          = 9'd509;
  localparam logic [8:0]  W_GIE          = 9'd510;
  localparam logic [8:0]  W_CTRL         = 9'd511;

  // Control bit positions (software-visible encoding).
  localparam int unsigned CB_STATUS = 0;
  localparam int unsigned CB_PROG   = 1;
  localparam int unsigned CB_IE     = 3;
  localparam int unsigned GIE_BIT   = 31;

  typedef enum logic [2:0] {K_NONE, K_DATA, K_LEN, K_GIE, K_CTRL} kind_e;

  typedef struct packed {
    logic                  bsel;
    kind_e                 kind;
    logic [ETX_WIDX_W-1:0] widx;
  } dec_t;

  typedef enum logic [0:0] {SQ_IDLE, SQ_RUN} sq_state_e;

  function automatic dec_t decode(input logic [ETX_ADDR_W-1:0] a);
    dec_t d;
    d.bsel = a[11];
    d.widx = a[10:2];
    if (a[12]) begin
      d.kind = K_NONE;
    end else begin
      case (d.widx)
        W_LEN:   d.kind = K_LEN;
        W_GIE:   d.kind = d.bsel ? K_NONE : K_GIE;
        W_CTRL:  d.kind = K_CTRL;
        default: d.kind = K_DATA;
      endcase
    end
    return d;
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [47:0] station_pack(input logic [31:0] w0, input logic [31:0] w1);
    return {w0[7:0], w0[15:8], w0[23:16], w0[31:24], w1[7:0], w1[15:8]};
  endfunction

  function automatic int unsigned clamp_len(input int unsigned len, input int unsigned cap);
    return (len > cap) ? cap : len;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic st, input logic pg, input logic ie);
    logic [31:0] r;
    r = '0;
    r[CB_STATUS] = st;
    r[CB_PROG]   = pg;
    r[CB_IE]     = ie;
    return r;
  endfunction

endpackage

// File: rtl/etx_buffer.sv
module etx_buffer
  import etx_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  data_we,
  input  logic [ETX_WIDX_W-1:0] wr_widx,
  input  logic [31:0]           wdata,
  input  logic                  len_we,
  input  logic                  ctrl_we,
  input  logic                  clr_status,
  input  logic [ETX_WIDX_W-1:0] bus_widx,
  input  logic [ETX_WIDX_W-1:0] seq_widx,
  output logic [31:0]           bus_word,
  output logic [31:0]           seq_word,
  output logic [31:0]           head0,
  output logic [31:0]           head1,
  output logic [LEN_W-1:0]      len,
  output logic                  status,
  output logic                  prog,
  output logic                  ie
);

  logic [31:0] mem [0:ETX_DATA_WORDS-1];

  always_ff @(posedge clk) begin
    if (data_we && (wr_widx < ETX_WIDX_W'(ETX_DATA_WORDS))) begin
      mem[wr_widx] <= wdata;
    end
  end

  always_comb begin
    bus_word = (bus_widx < ETX_WIDX_W'(ETX_DATA_WORDS)) ? mem[bus_widx] : '0;
    seq_word = (seq_widx < ETX_WIDX_W'(ETX_DATA_WORDS)) ? mem[seq_widx] : '0;
    head0    = mem[0];
    head1    = mem[1];
  end

  // A control write is accepted only while the buffer is idle.
  logic ctrl_accept;
  assign ctrl_accept = ctrl_we && !status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len    <= '0;
      status <= 1'b0;
      prog   <= 1'b0;
      ie     <= 1'b0;
    end else begin
      if (len_we) len <= wdata[LEN_W-1:0];
      if (ctrl_accept) begin
        status <= wdata[CB_STATUS];
        prog   <= wdata[CB_PROG];
        ie     <= wdata[CB_IE];
      end else if (clr_status) begin
        status <= 1'b0;
      end
    end
  end

  // R8: a write landing on a busy buffer leaves its control state untouched.
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && status && !clr_status) |=> (status && $stable(ie) && $stable(prog)));

  // R4: completion only clears a status bit that was set.
  assert_clear_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |-> status);

endmodule

// File: rtl/etx_sequencer.sv
module etx_sequencer
  import etx_pkg::*;
#(
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned DATA_BYTES = 2036
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             pend,
  input  logic [1:0]             prog_req,
  input  logic [1:0][LEN_W-1:0]  len_in,
  input  logic [1:0][31:0]       word_in,
  input  logic [1:0][31:0]       head0_in,
  input  logic [1:0][31:0]       head1_in,
  input  logic                   tx_ready,
  output logic [ETX_WIDX_W-1:0]  seq_widx,
  output logic [7:0]             tx_data,
  output logic                   tx_valid,
  output logic                   tx_last,
  output logic                   done,
  output logic                   done_sel,
  output logic                   load_stn,
  output logic [47:0]            stn_value
);

  sq_state_e        state_q;
  logic             sel_q;
  logic             prog_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] idx_q;

  logic             pick;
  logic [LEN_W-1:0] pick_len;
  logic             running;
  logic             is_last;
  logic             beat;

  assign pick     = pend[0] ? 1'b0 : 1'b1;
  assign pick_len = LEN_W'(clamp_len(int'(len_in[pick]), DATA_BYTES));
  assign running  = (state_q == SQ_RUN);
  assign is_last  = (({1'b0, idx_q} + (LEN_W+1)'(1)) == {1'b0, cnt_q});

  assign tx_valid = running && !prog_q && (cnt_q != '0);
  assign tx_last  = tx_valid && is_last;
  assign tx_data  = lane_byte(word_in[sel_q], idx_q[1:0]);
  assign seq_widx = ETX_WIDX_W'(idx_q >> 2);
  assign beat     = tx_valid && tx_ready;

  assign done      = running && (prog_q || (cnt_q == '0) || (beat && is_last));
  assign done_sel  = sel_q;
  assign load_stn  = running && prog_q;
  assign stn_value = station_pack(head0_in[sel_q], head1_in[sel_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      sel_q   <= 1'b0;
      prog_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (|pend) begin
            sel_q   <= pick;
            prog_q  <= prog_req[pick];
            cnt_q   <= pick_len;
            idx_q   <= '0;
            state_q <= SQ_RUN;
          end
        end
        default: begin
          if (beat) idx_q <= idx_q + LEN_W'(1);
          if (done) state_q <= SQ_IDLE;
        end
      endcase
    end
  end

  // R11: a stalled byte stays put until taken.
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R6: completions are at least two cycles apart, so the pulse cannot widen.
  assert_done_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: the byte index never passes the capped data area.
  assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (idx_q < LEN_W'(DATA_BYTES)));

endmodule

// File: rtl/etx_station.sv
module etx_station #(
  parameter logic [47:0] RESET_ADDR = 48'h02_00_00_00_00_01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [47:0] value,
  output logic [47:0] addr
);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= RESET_ADDR;
    else if (load) addr <= value;
  end

endmodule

// File: rtl/dualbuf_eth_tx.sv
module dualbuf_eth_tx
  import etx_pkg::*;
#(
  parameter int unsigned LEN_W      = 12,
  parameter logic [47:0] RESET_ADDR = 48'h02_00_00_00_00_01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ETX_ADDR_W-1:0] bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [7:0]            tx_data,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic                  tx_last,
  output logic [47:0]           station_addr,
  output logic                  irq
);

  localparam int unsigned DATA_BYTES = ETX_DATA_WORDS * 4;

  dec_t dec;
  assign dec = decode(bus_addr);

  logic [1:0][31:0]      bus_word, seq_word_arr, head0_arr, head1_arr;
  logic [1:0][LEN_W-1:0] len_arr;
  logic [1:0]            status_arr, prog_arr, ie_arr, clr_arr;
  logic [ETX_WIDX_W-1:0] seq_widx;
  logic                  done, done_sel, load_stn;
  logic [47:0]           stn_value;
  logic                  gie_q;
  logic                  irq_q;
  logic [31:0]           rd_word;
  logic [31:0]           rdata_q;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    assign clr_arr[b] = done && (done_sel == 1'(b));

    etx_buffer #(.LEN_W(LEN_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_we    (bus_wr && (dec.kind == K_DATA) && (dec.bsel == 1'(b))),
      .wr_widx    (dec.widx),
      .wdata      (bus_wdata),
      .len_we     (bus_wr && (dec.kind == K_LEN)  && (dec.bsel == 1'(b))),
      .ctrl_we    (bus_wr && (dec.kind == K_CTRL) && (dec.bsel == 1'(b))),
      .clr_status (clr_arr[b]),
      .bus_widx   (dec.widx),
      .seq_widx   (seq_widx),
      .bus_word   (bus_word[b]),
      .seq_word   (seq_word_arr[b]),
      .head0      (head0_arr[b]),
      .head1      (head1_arr[b]),
      .len        (len_arr[b]),
      .status     (status_arr[b]),
      .prog       (prog_arr[b]),
      .ie         (ie_arr[b])
    );
  end

  etx_sequencer #(.LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (status_arr),
    .prog_req  (prog_arr),
    .len_in    (len_arr),
    .word_in   (seq_word_arr),
    .head0_in  (head0_arr),
    .head1_in  (head1_arr),
    .tx_ready  (tx_ready),
    .seq_widx  (seq_widx),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .done      (done),
    .done_sel  (done_sel),
    .load_stn  (load_stn),
    .stn_value (stn_value)
  );

  etx_station #(.RESET_ADDR(RESET_ADDR)) u_stn (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_stn),
    .value (stn_value),
    .addr  (station_addr)
  );

  // Read mux: registered, one cycle of latency.
  always_comb begin
    case (dec.kind)
      K_DATA:  rd_word = bus_word[dec.bsel];
      K_LEN:   rd_word = 32'(len_arr[dec.bsel]);
      K_GIE:   rd_word = {gie_q, 31'b0};
      K_CTRL:  rd_word = ctrl_word(status_arr[dec.bsel], prog_arr[dec.bsel], ie_arr[dec.bsel]);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && (dec.kind == K_GIE)) gie_q <= bus_wdata[GIE_BIT];
      irq_q   <= done && ie_arr[done_sel] && gie_q;
      rdata_q <= bus_rd ? rd_word : '0;
    end
  end

  assign irq       = irq_q;
  assign bus_rdata = rdata_q;

  // R6: interrupt is a lone pulse and needs the global enable.
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_needs_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_q));

  // R5: the station address changes only on a program completion.
  assert_station_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stn |=> $stable(station_addr));

  // R5: no stream beat while a program operation completes.
  assert_prog_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_stn |-> !tx_valid);

endmodule

// File: tb/dualbuf_eth_tx_test.sv
module dualbuf_eth_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, irq;
  logic        tx_ready = 1'b1;
  logic [47:0] station_addr;

  localparam logic [47:0] RST_MAC = 48'h02_00_00_00_00_01;

  always #5 clk = ~clk;

  dualbuf_eth_tx uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .station_addr(station_addr), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Ready driver: held low, toggling, or always high.
  logic hold = 1'b0, stall_mode = 1'b0;
  always @(negedge clk) tx_ready <= hold ? 1'b0 : (stall_mode ? ~tx_ready : 1'b1);

  // Stream and interrupt monitor.
  logic [7:0] cap [0:4095];
  int  cap_n = 0, last_cnt = 0, last_pos = -1, irq_cnt = 0;
  logic mon_clr = 1'b0;
  always @(posedge clk) begin
    if (mon_clr) begin
      cap_n <= 0; last_cnt <= 0; last_pos <= -1; irq_cnt <= 0;
    end else begin
      if (rst_n && tx_valid && tx_ready) begin
        cap[cap_n] <= tx_data;
        cap_n <= cap_n + 1;
        if (tx_last) begin last_cnt <= last_cnt + 1; last_pos <= cap_n; end
      end
      if (irq) irq_cnt <= irq_cnt + 1;
    end
  end

  typedef struct packed {
    logic        bsel;
    logic [11:0] len;
    logic [3:0]  ctrl;
    logic        gie;
    logic [7:0]  seed;
    logic        stall;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b0, 12'd7,  4'h9, 1'b1, 8'd11, 1'b0, 1'b1},
    '{1'b1, 12'd16, 4'h1, 1'b1, 8'd22, 1'b1, 1'b0},
    '{1'b1, 12'd5,  4'h9, 1'b0, 8'd33, 1'b1, 1'b0},
    '{1'b0, 12'd1,  4'h9, 1'b1, 8'd44, 1'b0, 1'b1},
    '{1'b1, 12'd64, 4'h9, 1'b1, 8'd55, 1'b1, 1'b1},
    '{1'b0, 12'd0,  4'h9, 1'b1, 8'd66, 1'b0, 1'b1}
  };

  function automatic logic [31:0] pat(input int seed, input int w);
    return (32'(seed) * 32'h0100_0193) ^ (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [7:0] exp_byte(input int seed, input int k);
    logic [31:0] w;
    w = pat(seed, k / 4);
    return w[8*(k%4) +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [12:0] base_of(input logic b);
    return b ? 13'h800 : 13'h000;
  endfunction

  task automatic fill(input logic b, input int seed, input int nwords);
    for (int w = 0; w < nwords; w++) bus_write(base_of(b) + 13'(w * 4), pat(seed, w));
  endtask

  task automatic wait_idle(input logic b);
    logic [31:0] d;
    for (int i = 0; i < 6000; i++) begin
      bus_read(base_of(b) + 13'h7FC, d);
      if (!d[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic cmp_seg(input int base, input int seed, input int n, input string req);
    int bad = -1;
    for (int k = 0; k < n; k++) if (bad < 0 && cap[base + k] !== exp_byte(seed, k)) bad = k;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, 64'(cap[base + bad]), 64'(exp_byte(seed, bad)));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq === 1'b0, "R1 irq", 64'(irq), 0);
    check(tx_valid === 1'b0, "R1 tx_valid", 64'(tx_valid), 0);
    check(station_addr === RST_MAC, "R1 station", 64'(station_addr), 64'(RST_MAC));
    bus_read(13'h7FC, d); check(d === 32'h0, "R1 ctrl0", 64'(d), 0);
    bus_read(13'hFFC, d); check(d === 32'h0, "R1 ctrl1", 64'(d), 0);
    bus_read(13'h7F8, d); check(d === 32'h0, "R1 gie", 64'(d), 0);

    // R2 register map and readback
    bus_write(13'h804, 32'hCAFE_F00D);
    bus_read(13'h804, d); check(d === 32'hCAFE_F00D, "R2 data1", 64'(d), 64'hCAFEF00D);
    bus_write(13'h7F4, 32'hFFFF_F123);
    bus_read(13'h7F4, d); check(d === 32'h123, "R2 len0", 64'(d), 64'h123);
    bus_write(13'h1000, 32'h1234_5678);
    bus_read(13'h1000, d); check(d === 32'h0, "R2 high region", 64'(d), 0);
    bus_write(13'h7F8, 32'h8000_0000);
    bus_read(13'h7F8, d); check(d === 32'h8000_0000, "R2 gie", 64'(d), 64'h80000000);

    // Table walk: R3 stream order, R4 status, R6 irq gating, R10 zero length, R11 stall
    for (int v = 0; v < 6; v++) begin
      vec_t t;
      int   nw;
      t  = VECS[v];
      nw = (int'(t.len) + 3) / 4;
      stall_mode = t.stall;
      fill(t.bsel, int'(t.seed), nw);
      bus_write(base_of(t.bsel) + 13'h7F4, 32'(t.len));
      bus_write(13'h7F8, {t.gie, 31'b0});
      clear_mon();
      bus_write(base_of(t.bsel) + 13'h7FC, 32'(t.ctrl));
      if (t.len >= 12'd4) begin
        bus_read(base_of(t.bsel) + 13'h7FC, d);
        check(d[0] === 1'b1, "R4 busy", 64'(d), 64'(t.ctrl));
      end
      wait_idle(t.bsel);
      bus_read(base_of(t.bsel) + 13'h7FC, d);
      check(d === 32'(t.ctrl & 4'hE), "R4 done readback", 64'(d), 64'(t.ctrl & 4'hE));
      check(cap_n == int'(t.len), "R3 byte count", 64'(cap_n), 64'(t.len));
      cmp_seg(0, int'(t.seed), int'(t.len), "R3 byte order");
      if (t.len != 0) check(last_cnt == 1 && last_pos == int'(t.len) - 1, "R3 last",
                            64'(last_pos), 64'(int'(t.len) - 1));
      else check(last_cnt == 0, "R10 zero length no last", 64'(last_cnt), 0);
      check(irq_cnt == int'(t.exp_irq), "R6 irq count", 64'(irq_cnt), 64'(t.exp_irq));
    end
    stall_mode = 1'b0;

    // R5 program station address from buffer 1
    bus_write(13'h800, 32'h3412_00AA);
    bus_write(13'h804, 32'h0000_7856);
    bus_write(13'h7F8, 32'h8000_0000);
    clear_mon();
    bus_write(13'hFFC, 32'hB);
    wait_idle(1'b1);
    check(station_addr === 48'hAA00_1234_5678, "R5 station", 64'(station_addr), 64'hAA0012345678);
    check(cap_n == 0, "R5 no stream", 64'(cap_n), 0);
    check(irq_cnt == 1, "R6 program irq", 64'(irq_cnt), 1);
    bus_read(13'hFFC, d); check(d === 32'hA, "R4 program readback", 64'(d), 64'hA);

    // R7 buffer 1's enable slot is inert
    bus_write(13'h7F8, 32'h0);
    bus_write(13'hFF8, 32'h8000_0000);
    bus_read(13'hFF8, d); check(d === 32'h0, "R7 read", 64'(d), 0);
    bus_read(13'h7F8, d); check(d === 32'h0, "R7 gie unchanged", 64'(d), 0);
    fill(1'b1, 88, 1);
    bus_write(13'hFF4, 32'd2);
    clear_mon();
    bus_write(13'hFFC, 32'h9);
    wait_idle(1'b1);
    check(irq_cnt == 0, "R7 no irq", 64'(irq_cnt), 0);
    check(cap_n == 2, "R7 bytes", 64'(cap_n), 2);

    // R8 write while busy ignored
    bus_write(13'h7F8, 32'h8000_0000);
    fill(1'b0, 99, 2);
    bus_write(13'h7F4, 32'd8);
    hold = 1'b1;
    clear_mon();
    bus_write(13'h7FC, 32'h9);
    bus_write(13'h7FC, 32'h3);
    repeat (4) @(negedge clk);
    hold = 1'b0;
    wait_idle(1'b0);
    bus_read(13'h7FC, d); check(d === 32'h8, "R8 ctrl kept", 64'(d), 64'h8);
    check(station_addr === 48'hAA00_1234_5678, "R8 station kept", 64'(station_addr), 64'hAA0012345678);
    check(cap_n == 8, "R8 bytes", 64'(cap_n), 8);
    cmp_seg(0, 99, 8, "R8 data");
    check(irq_cnt == 1, "R8 irq", 64'(irq_cnt), 1);

    // R9 start of buffer 1 coincides with buffer 0 completion
    fill(1'b0, 17, 1);
    fill(1'b1, 23, 2);
    bus_write(13'h7F4, 32'd3);
    bus_write(13'hFF4, 32'd5);
    clear_mon();
    bus_write(13'h7FC, 32'h9);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tx_valid && tx_last) break;
    end
    bus_wr = 1'b1; bus_addr = 13'hFFC; bus_wdata = 32'h9;
    @(negedge clk); bus_wr = 1'b0;
    wait_idle(1'b1);
    check(cap_n == 8, "R9 total bytes", 64'(cap_n), 8);
    cmp_seg(0, 17, 3, "R9 first frame");
    cmp_seg(3, 23, 5, "R9 second frame");
    check(last_cnt == 2, "R9 last beats", 64'(last_cnt), 2);
    check(irq_cnt == 2, "R9 irq pulses", 64'(irq_cnt), 2);

    // R10 length above the data area is capped
    fill(1'b0, 77, 509);
    bus_write(13'h7F4, 32'hFFF);
    clear_mon();
    bus_write(13'h7FC, 32'h1);
    wait_idle(1'b0);
    check(cap_n == 2036, "R10 clamp count", 64'(cap_n), 2036);
    check(last_pos == 2035, "R10 clamp last", 64'(last_pos), 2035);
    cmp_seg(0, 77, 2036, "R10 clamp data");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule